// File: doc/BRIEF.md
# Two-Region Memory Attribute Matcher

This block classifies physical addresses into one of three memory attributes: uncacheable, write-combining or default. A single 64-bit configuration word describes two regions, each in its own 32-bit half. Every region half carries three things: an aligned base, a size mask in 128 KB units that selects which upper address bits take part in the compare, and a two-bit kind. A lookup presents a 32-bit address, and one cycle later the block returns the resolved attribute.

The configuration changes only through a guarded write path. The block accepts a new word on a valid/ready port and then raises a flush request toward the cache. It holds that request until the cache acknowledges a complete write-back-and-invalidate. Only then does the new word replace the live one. The live word can be read back at any time, so software can see when a change has taken hold.

Top module: `mem_attr_matcher`

## Requirements
- R1: After reset the configuration reads back as zero, `wr_ready` is high, `flush_req` and `res_valid` are low, and every lookup resolves to default.
- R2: Region 0 is described by configuration bits 31:0 and region 1 by bits 63:32. `cfg_rdata` always shows the committed word.
- R3: Inside a region half, bits 31:17 hold the base and bits 16:2 hold the mask. An address hits when its bits 31:17, ANDed with the mask, equal the base ANDed with the mask.
- R4: If kind bit 1 is set, the region is write-combining, and this includes kind 3. If only kind bit 0 is set, the region is uncacheable. Kind 0 disables the region, so an all-zero half matches nothing.
- R5: `res_attr` encodes default as 2'b00, uncacheable as 2'b01 and write-combining as 2'b10. Uncacheable wins when both regions hit, and default results when neither hits.
- R6: A write accepted with `wr_valid` and `wr_ready` raises `flush_req` on the next cycle. `flush_req` stays high until `flush_ack` is sampled, and `wr_ready` stays low for as long as `flush_req` is high.
- R7: The configuration takes the accepted word at the clock edge that samples `flush_ack` high while the request is pending. From the next cycle `cfg_rdata` shows the new word, `flush_req` is low and `wr_ready` is high.
- R8: A `flush_ack` that arrives with no request pending has no effect. A `wr_valid` that arrives while `wr_ready` is low is not captured.
- R9: `res_valid` is high exactly one cycle after `lk_valid`. A lookup sampled on the same edge as a commit is resolved against the old configuration.
- R10: A mask of 0x1FFFC covers exactly 128 KB and a mask of 0x1FFF0 covers exactly 512 KB above an aligned base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | New configuration word offered |
| wr_data | input | 64 | Offered configuration word |
| wr_ready | output | 1 | Write port can accept a word |
| flush_req | output | 1 | Request for cache write-back-and-invalidate |
| flush_ack | input | 1 | Cache reports that the flush is complete |
| cfg_rdata | output | 64 | Committed configuration word |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Physical address to classify |
| res_valid | output | 1 | Lookup result valid, one cycle after the request |
| res_attr | output | 2 | Resolved attribute |

## Verification
The assertions assume that reset is applied from the first clock edge. They also assume the cache answers with `flush_ack` only while `flush_req` is high, apart from deliberate stray pulses. The stimulus holds reset from time zero and then programs only size-aligned, power-of-two regions, because the bench's range model matches the mask compare only for such regions. Stray acknowledges and offers made while the port is busy are issued on purpose, to show that neither one moves the committed word.

// File: rtl/mattr_pkg.sv
package mattr_pkg;

    parameter int unsigned ADDR_W   = 32;
    parameter int unsigned N_REGION = 2;
    parameter int unsigned GRAN_LSB = 17;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned CFG_W   = WORD_W * N_REGION;
    localparam int unsigned FIELD_W = ADDR_W - GRAN_LSB;

    typedef enum logic [1:0] {
        ATTR_DEFAULT = 2'b00,
        ATTR_UC      = 2'b01,
        ATTR_WC      = 2'b10
    } attr_e;

    typedef enum logic {
        CM_IDLE  = 1'b0,
        CM_FLUSH = 1'b1
    } commit_e;

    // one region half: base in [31:17], mask in [16:2], kind in [1:0]
    typedef struct packed {
        logic [FIELD_W-1:0] base;
        logic [FIELD_W-1:0] mask;
        logic [1:0]         kind;
    } region_t;

    function automatic attr_e kind_to_attr(input logic [1:0] kind);
        if (kind[1])      return ATTR_WC;
        else if (kind[0]) return ATTR_UC;
        else              return ATTR_DEFAULT;
    endfunction

endpackage

// File: rtl/mattr_region_match.sv
module mattr_region_match
    import mattr_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned FW = FIELD_W
) (
    input  region_t         rgn,
    input  logic [FW-1:0]   addr_hi,
    output attr_e           hit_attr
);

    logic enabled;
    logic hit;

    always_comb begin
        enabled  = (rgn.kind != 2'b00);
        hit      = enabled && ((addr_hi & rgn.mask) == (rgn.base & rgn.mask));
        hit_attr = hit ? kind_to_attr(rgn.kind) : ATTR_DEFAULT;
    end

endmodule

// File: rtl/mattr_cfg_commit.sv
module mattr_cfg_commit
    import mattr_pkg::*;
#(
    parameter int unsigned CW = CFG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic [CW-1:0] wr_data,
    output logic          wr_ready,
    output logic          flush_req,
    input  logic          flush_ack,
    output logic [CW-1:0] cfg_q
);

    commit_e       st_q;
    logic [CW-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= CM_IDLE;
            pend_q <= '0;
            cfg_q  <= '0;
        end else begin
            case (st_q)
                CM_IDLE: begin
                    if (wr_valid) begin
                        pend_q <= wr_data;
                        st_q   <= CM_FLUSH;
                    end
                end
                CM_FLUSH: begin
                    if (flush_ack) begin
                        cfg_q <= pend_q;
                        st_q  <= CM_IDLE;
                    end
                end
                default: st_q <= CM_IDLE;
            endcase
        end
    end

    assign wr_ready  = (st_q == CM_IDLE);
    assign flush_req = (st_q == CM_FLUSH);

    // R1: reset clears the committed word and any pending flush
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (cfg_q == '0 && !flush_req && wr_ready));

    // R6: port is busy while the flush is outstanding
    p_busy_in_flush_r6: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> !wr_ready);

    p_accept_flush_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |=> flush_req);

    p_req_held_r6: assert property (@(posedge clk) disable iff (rst)
        (flush_req && !flush_ack) |=> flush_req);

    // R7: acknowledge closes the handshake
    p_ack_closes_r7: assert property (@(posedge clk) disable iff (rst)
        (flush_req && flush_ack) |=> (wr_ready && !flush_req));

    // R8: nothing but an answered flush moves the committed word
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(flush_req && flush_ack) |=> $stable(cfg_q));

endmodule

// File: rtl/mattr_lookup_stage.sv
module mattr_lookup_stage
    import mattr_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned NR = N_REGION,
    parameter int unsigned GL = GRAN_LSB
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NR*32-1:0] cfg,
    input  logic             lk_valid,
    input  logic [AW-1:0]    lk_addr,
    output logic             res_valid,
    output attr_e            res_attr
);

    localparam int unsigned FW = AW - GL;

    logic [FW-1:0] addr_hi;
    logic          unused_lo;
    attr_e         hit_attr [NR];
    attr_e         merged;

    assign addr_hi   = lk_addr[AW-1:GL];
    assign unused_lo = ^lk_addr[GL-1:0];

    for (genvar g = 0; g < NR; g++) begin : g_region
        mattr_region_match #(.AW(AW), .FW(FW)) u_match (
            .rgn      (region_t'(cfg[g*32 +: 32])),
            .addr_hi  (addr_hi),
            .hit_attr (hit_attr[g])
        );
    end

    always_comb begin
        logic any_uc;
        logic any_wc;
        any_uc = 1'b0;
        any_wc = 1'b0;
        for (int i = 0; i < NR; i++) begin
            if (hit_attr[i] == ATTR_UC) any_uc = 1'b1;
            if (hit_attr[i] == ATTR_WC) any_wc = 1'b1;
        end
        if (any_uc)      merged = ATTR_UC;
        else if (any_wc) merged = ATTR_WC;
        else             merged = ATTR_DEFAULT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_attr  <= ATTR_DEFAULT;
        end else begin
            res_valid <= lk_valid;
            if (lk_valid) res_attr <= merged;
        end
    end

    // R9: one cycle of latency, no spurious results
    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid);

    p_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !res_valid);

    // R5: only the three legal codes ever leave the block
    p_legal_code_r5: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_attr != 2'b11));

    // R4: an all-zero configuration matches nothing
    p_all_off_r4: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && cfg == '0) |=> (res_attr == ATTR_DEFAULT));

endmodule

// File: rtl/mem_attr_matcher.sv
module mem_attr_matcher
    import mattr_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned NR = N_REGION
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [NR*32-1:0] wr_data,
    output logic             wr_ready,
    output logic             flush_req,
    input  logic             flush_ack,
    output logic [NR*32-1:0] cfg_rdata,
    input  logic             lk_valid,
    input  logic [AW-1:0]    lk_addr,
    output logic             res_valid,
    output logic [1:0]       res_attr
);

    localparam int unsigned CW = NR * 32;

    logic [CW-1:0] cfg_q;
    attr_e         attr_w;

    mattr_cfg_commit #(.CW(CW)) u_commit (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .wr_ready  (wr_ready),
        .flush_req (flush_req),
        .flush_ack (flush_ack),
        .cfg_q     (cfg_q)
    );

    mattr_lookup_stage #(.AW(AW), .NR(NR), .GL(GRAN_LSB)) u_lookup (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg_q),
        .lk_valid  (lk_valid),
        .lk_addr   (lk_addr),
        .res_valid (res_valid),
        .res_attr  (attr_w)
    );

    assign cfg_rdata = cfg_q;
    assign res_attr  = attr_w;

endmodule

// File: tb/sim_mem_attr_matcher.sv
module sim_mem_attr_matcher;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [63:0] wr_data = '0;
    logic        wr_ready;
    logic        flush_req;
    logic        flush_ack = 1'b0;
    logic [63:0] cfg_rdata;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        res_valid;
    logic [1:0]  res_attr;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] model = '0;

    always #10 clk = ~clk;

    mem_attr_matcher u0 (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .flush_req(flush_req), .flush_ack(flush_ack),
        .cfg_rdata(cfg_rdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .res_valid(res_valid), .res_attr(res_attr)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // range model: base .. base+size-1, size from the inverted mask
    function automatic logic [1:0] exp_attr(input logic [63:0] c, input logic [31:0] a);
        logic [31:0] w;
        longint unsigned base, size, ad;
        logic uc, wc;
        uc = 1'b0;
        wc = 1'b0;
        ad = longint'(a);
        for (int i = 0; i < 2; i++) begin
            w    = c[i*32 +: 32];
            base = longint'(w & 32'hFFFE_0000);
            size = (longint'(~w & 32'h0001_FFFC) + 64'd4) << 15;
            if (w[1:0] != 2'b00 && ad >= base && ad < base + size) begin
                if (w[1]) wc = 1'b1;
                else      uc = 1'b1;
            end
        end
        return uc ? 2'b01 : (wc ? 2'b10 : 2'b00);
    endfunction

    task automatic look(input string tag, input logic [31:0] a);
        lk_valid = 1'b1;
        lk_addr  = a;
        tick();
        lk_valid = 1'b0;
        chk({tag, " R9 res_valid"}, 64'(res_valid), 64'd1);
        chk(tag, 64'(res_attr), 64'(exp_attr(model, a)));
        tick();
        chk({tag, " R9 res_valid drop"}, 64'(res_valid), 64'd0);
    endtask

    task automatic do_write(input logic [63:0] d, input int wait_cyc);
        chk("R6 ready before write", 64'(wr_ready), 64'd1);
        wr_valid = 1'b1;
        wr_data  = d;
        tick();
        wr_valid = 1'b0;
        chk("R6 flush_req raised", 64'(flush_req), 64'd1);
        chk("R6 ready low", 64'(wr_ready), 64'd0);
        for (int k = 0; k < wait_cyc; k++) begin
            tick();
            chk("R6 flush_req held", 64'(flush_req), 64'd1);
            chk("R7 old word kept before ack", cfg_rdata, model);
        end
        flush_ack = 1'b1;
        tick();
        flush_ack = 1'b0;
        model = d;
        chk("R7 word committed", cfg_rdata, d);
        chk("R7 ready back", 64'(wr_ready), 64'd1);
        chk("R7 flush_req dropped", 64'(flush_req), 64'd0);
    endtask

    task automatic t_reset();
        chk("R1 cfg zero", cfg_rdata, 64'd0);
        chk("R1 ready", 64'(wr_ready), 64'd1);
        chk("R1 no flush", 64'(flush_req), 64'd0);
        chk("R1 no result", 64'(res_valid), 64'd0);
        look("R1 default lookup", 32'h0010_0000);
    endtask

    task automatic t_small_region();
        do_write({32'h0, 32'h0011_FFFD}, 2);
        look("R3 low edge", 32'h0010_0000);
        look("R3 high edge", 32'h0011_FFFF);
        look("R10 past 128K", 32'h0012_0000);
        look("R3 below base", 32'h000F_FFFF);
    endtask

    task automatic t_upper_half();
        do_write({32'h0081_FFF2, 32'h0011_FFFD}, 0);
        look("R10 512K last", 32'h0087_FFFF);
        look("R10 512K past", 32'h0088_0000);
        look("R2 region0 still", 32'h0010_8000);
    endtask

    task automatic t_priority();
        do_write({32'h0109_FFFD, 32'h0101_FFE2}, 1);
        look("R5 both hit", 32'h0108_0010);
        look("R5 only wc", 32'h010F_FFFF);
        look("R5 wc below", 32'h0107_FFFF);
        look("R5 neither", 32'h0110_0000);
    endtask

    task automatic t_kinds();
        do_write({32'h0021_FFFC, 32'h0041_FFFF}, 3);
        chk("R4 kind3 expect", 64'(exp_attr(model, 32'h0040_0100)), 64'd2);
        look("R4 kind3 is wc", 32'h0040_0100);
        look("R4 kind0 off", 32'h0020_0100);
    endtask

    task automatic t_commit_edge();
        logic [63:0] old;
        old = model;
        chk("R6 ready", 64'(wr_ready), 64'd1);
        wr_valid = 1'b1;
        wr_data  = {32'h0, 32'h0021_FFFD};
        tick();
        wr_valid  = 1'b0;
        flush_ack = 1'b1;
        lk_valid  = 1'b1;
        lk_addr   = 32'h0020_0100;
        tick();
        flush_ack = 1'b0;
        lk_valid  = 1'b0;
        model = {32'h0, 32'h0021_FFFD};
        chk("R9 same-edge uses old", 64'(res_attr), 64'(exp_attr(old, 32'h0020_0100)));
        chk("R7 new word", cfg_rdata, model);
        tick();
        look("R9 next lookup new", 32'h0020_0100);
    endtask

    task automatic t_ignored();
        flush_ack = 1'b1;
        tick();
        flush_ack = 1'b0;
        chk("R8 stray ack cfg", cfg_rdata, model);
        chk("R8 stray ack no req", 64'(flush_req), 64'd0);
        chk("R8 stray ack ready", 64'(wr_ready), 64'd1);
        wr_valid = 1'b1;
        wr_data  = {32'h0081_FFF2, 32'h0};
        tick();
        wr_data  = 64'hFFFF_FFFF_FFFF_FFFF;
        tick();
        wr_valid  = 1'b0;
        flush_ack = 1'b1;
        tick();
        flush_ack = 1'b0;
        model = {32'h0081_FFF2, 32'h0};
        chk("R8 busy offer dropped", cfg_rdata, model);
        chk("R8 ready after", 64'(wr_ready), 64'd1);
        tick();
        chk("R8 no second flush", 64'(flush_req), 64'd0);
        look("R8 wc region", 32'h0080_0000);
    endtask

    task automatic t_zero();
        do_write(64'd0, 0);
        look("R4 all zero off", 32'h0080_0000);
        look("R2 zero other", 32'h0010_0000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick();
        tick();
        tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_small_region();
        t_upper_half();
        t_priority();
        t_kinds();
        t_commit_edge();
        t_ignored();
        t_zero();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule